// File: doc/BRIEF.md
# Configuration Invalidation Sequencer

This block sits behind the command decoder of an address-translation unit. It takes one decoded configuration-invalidation command at a time and turns it into one or more invalidation operations. Each operation goes out on a shared invalidation bus. The bus has three kinds of listener: the central configuration cache, and the micro TLB and main TLB of every device interface. An operation is complete only when all of these listeners have acknowledged it. No device interface can then serve a translation that was built from stale configuration.

A command either names one stream, or one stream plus a substream, or an aligned power-of-two window of streams. A window command is expanded into a run of single-stream operations, one per SID, from the lowest SID of the window to the highest. The command port is held busy until the last operation has been acknowledged. A command type the block does not recognise is consumed without touching the bus, and an error pulse is raised.

The controller has three states:
- `ST_IDLE`: ready for a command.
- `ST_ISSUE`: an operation is on the bus, waiting for acknowledges.
- `ST_REJECT`: a one-cycle error pulse for an unknown command.

The transitions are:
- `ST_IDLE` goes to `ST_ISSUE` on accepting a known command.
- `ST_IDLE` goes to `ST_REJECT` on accepting an unknown command.
- `ST_ISSUE` stays in `ST_ISSUE` while it advances to the next SID once every acknowledge is in and the SID is not the last.
- `ST_ISSUE` goes to `ST_IDLE` once every acknowledge is in for the last SID.
- `ST_REJECT` goes to `ST_IDLE` unconditionally.

Top module: `cfginv_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `inv_valid` is 0 and `cmd_err` is 0.
- R2: A command with `cmd_kind` = 0 (single stream) issues exactly one operation with `inv_op` = 0 (by SID) and `inv_sid` equal to `cmd_sid`.
- R3: A command with `cmd_kind` = 1 (stream window) and `cmd_range` = 31 issues exactly one operation with `inv_op` = 2 (invalidate all).
- R4: A command with `cmd_kind` = 1 and `cmd_range` below 31 starts at `cmd_sid` with its low `cmd_range`+1 bits cleared, where all SID bits are cleared if `cmd_range`+1 is at least the SID width. It then issues by-SID operations (`inv_op` = 0) whose SID rises by exactly one per operation.
- R5: The final SID of such a window is the start SID plus 2^(`cmd_range`+1) minus 1, limited to the all-ones SID. The total operation count is therefore 2^(`cmd_range`+1), capped at 2^SID width.
- R6: A command with `cmd_kind` = 2 (substream) issues exactly one operation with `inv_op` = 1 (by SID and SSID), carrying `cmd_sid` and `cmd_ssid`.
- R7: A command with `cmd_kind` = 3 (all substreams of a stream) issues exactly one operation with `inv_op` = 0 and `inv_sid` equal to `cmd_sid`.
- R8: An operation stays on the bus with the same `inv_sid` and `inv_op` until `cfg_ack` and every bit of `utlb_ack` and `mtlb_ack` have been seen. Acknowledges may arrive in different cycles, and each one is remembered until the operation completes.
- R9: `cmd_ready` is 0 from the cycle after acceptance until the cycle after the last operation's final acknowledge. In that cycle `cmd_ready` is 1 and `inv_valid` is 0.
- R10: A command with `cmd_kind` 4 to 7 is accepted, issues no operation, and drives `cmd_err` high for exactly the one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_kind | input | 3 | Command type (0 stream, 1 window, 2 substream, 3 stream-all-substreams) |
| cmd_sid | input | SID_W | Stream identifier |
| cmd_ssid | input | SSID_W | Substream identifier |
| cmd_range | input | 5 | Window size exponent minus one; 31 means everything |
| inv_valid | output | 1 | Invalidation operation on the bus |
| inv_op | output | 2 | 0 by SID, 1 by SID and SSID, 2 all |
| inv_sid | output | SID_W | SID of the current operation |
| inv_ssid | output | SSID_W | SSID of the current operation |
| cfg_ack | input | 1 | Configuration cache acknowledge |
| utlb_ack | input | NUM_IF | Per-interface micro TLB acknowledges |
| mtlb_ack | input | NUM_IF | Per-interface main TLB acknowledges |
| cmd_err | output | 1 | One-cycle pulse for an unrecognised command |

## Verification
Timing is counted from the accepting clock edge:
- `inv_valid` and the first operation's SID appear one edge after acceptance, and `cmd_ready` falls at the same edge. `cmd_err` also rises one edge after acceptance and falls one edge later.
- Each later SID of a window appears one edge after the edge on which the last missing acknowledge is sampled.
- After the final operation, `cmd_ready` rises one edge after the last acknowledge.

The bench drives inputs and samples every output on the falling edge, so each of these values is read half a period after the edge that produced it. The operation log is recorded by the same falling-edge process that models the listeners. A new entry is logged whenever `inv_valid` is high with a SID different from the one seen on the previous falling edge.

// File: rtl/cfginv_pkg.sv
package cfginv_pkg;

    localparam int RANGE_W = 5;
    localparam logic [RANGE_W-1:0] RANGE_EVERYTHING = 5'd31;

    localparam logic [2:0] KIND_STREAM     = 3'd0;
    localparam logic [2:0] KIND_WINDOW     = 3'd1;
    localparam logic [2:0] KIND_SUBSTREAM  = 3'd2;
    localparam logic [2:0] KIND_STREAM_ALL = 3'd3;

    typedef enum logic [1:0] {
        OP_BY_SID      = 2'd0,
        OP_BY_SID_SSID = 2'd1,
        OP_ALL         = 2'd2
    } inv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cfginv_decode.sv
module cfginv_decode
    import cfginv_pkg::*;
#(
    parameter int SID_W = 8
) (
    input  logic [2:0]         kind,
    input  logic [SID_W-1:0]   sid,
    input  logic [RANGE_W-1:0] rng,
    output logic               known,
    output inv_op_e            op,
    output logic [SID_W-1:0]   first_sid,
    output logic [SID_W-1:0]   last_sid
);

    // Window mask: bit g is set when g lies inside the low rng+1 bits.
    logic [SID_W-1:0] win_mask;

    generate
        for (genvar g = 0; g < SID_W; g++) begin : g_mask
            assign win_mask[g] = (int'(rng) >= g);
        end
    endgenerate

    always_comb begin
        known     = 1'b1;
        op        = OP_BY_SID;
        first_sid = sid;
        last_sid  = sid;
        unique case (kind)
            KIND_STREAM: begin
                op = OP_BY_SID;
            end
            KIND_WINDOW: begin
                if (rng == RANGE_EVERYTHING) begin
                    op        = OP_ALL;
                    first_sid = '0;
                    last_sid  = '0;
                end else begin
                    op        = OP_BY_SID;
                    first_sid = sid & ~win_mask;
                    last_sid  = (sid & ~win_mask) | win_mask;
                end
            end
            KIND_SUBSTREAM: begin
                op = OP_BY_SID_SSID;
            end
            KIND_STREAM_ALL: begin
                op = OP_BY_SID;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfginv_ack_join.sv
module cfginv_ack_join #(
    parameter int NUM_IF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              clear,
    input  logic              cfg_ack,
    input  logic [NUM_IF-1:0] utlb_ack,
    input  logic [NUM_IF-1:0] mtlb_ack,
    output logic              all_acked
);

    localparam int NUM_TGT = 1 + 2 * NUM_IF;

    logic [NUM_TGT-1:0] ack_now;
    logic [NUM_TGT-1:0] seen_q;

    assign ack_now = {mtlb_ack, utlb_ack, cfg_ack};

    generate
        for (genvar t = 0; t < NUM_TGT; t++) begin : g_sticky
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seen_q[t] <= 1'b0;
                end else if (clear) begin
                    seen_q[t] <= 1'b0;
                end else if (active && ack_now[t]) begin
                    seen_q[t] <= 1'b1;
                end
            end
        end
    endgenerate

    assign all_acked = active && (&(seen_q | ack_now));

endmodule

// File: rtl/cfginv_seq.sv
module cfginv_seq
    import cfginv_pkg::*;
#(
    parameter int SID_W  = 8,
    parameter int SSID_W = 6,
    parameter int NUM_IF = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_kind,
    input  logic [SID_W-1:0]   cmd_sid,
    input  logic [SSID_W-1:0]  cmd_ssid,
    input  logic [4:0]         cmd_range,
    output logic               inv_valid,
    output logic [1:0]         inv_op,
    output logic [SID_W-1:0]   inv_sid,
    output logic [SSID_W-1:0]  inv_ssid,
    input  logic               cfg_ack,
    input  logic [NUM_IF-1:0]  utlb_ack,
    input  logic [NUM_IF-1:0]  mtlb_ack,
    output logic               cmd_err
);

    seq_state_e        state_q, state_d;
    logic [SID_W-1:0]  cur_sid_q, last_sid_q;
    logic [SSID_W-1:0] ssid_q;
    inv_op_e           op_q;

    logic              dec_known;
    inv_op_e           dec_op;
    logic [SID_W-1:0]  dec_first, dec_last;
    logic              accept;
    logic              issuing;
    logic              all_acked;
    logic              final_step;

    cfginv_decode #(
        .SID_W (SID_W)
    ) u_decode (
        .kind      (cmd_kind),
        .sid       (cmd_sid),
        .rng       (cmd_range),
        .known     (dec_known),
        .op        (dec_op),
        .first_sid (dec_first),
        .last_sid  (dec_last)
    );

    cfginv_ack_join #(
        .NUM_IF (NUM_IF)
    ) u_join (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (issuing),
        .clear     (all_acked),
        .cfg_ack   (cfg_ack),
        .utlb_ack  (utlb_ack),
        .mtlb_ack  (mtlb_ack),
        .all_acked (all_acked)
    );

    assign accept     = cmd_valid && (state_q == ST_IDLE);
    assign issuing    = (state_q == ST_ISSUE);
    assign final_step = (cur_sid_q == last_sid_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = dec_known ? ST_ISSUE : ST_REJECT;
                end
            end
            ST_ISSUE: begin
                if (all_acked && final_step) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REJECT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Command context and SID walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sid_q  <= '0;
            last_sid_q <= '0;
            ssid_q     <= '0;
            op_q       <= OP_BY_SID;
        end else if (accept && dec_known) begin
            cur_sid_q  <= dec_first;
            last_sid_q <= dec_last;
            ssid_q     <= cmd_ssid;
            op_q       <= dec_op;
        end else if (issuing && all_acked && !final_step) begin
            cur_sid_q  <= cur_sid_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        inv_valid = (state_q == ST_ISSUE);
        cmd_err   = (state_q == ST_REJECT);
        inv_op    = op_q;
        inv_sid   = cur_sid_q;
        inv_ssid  = ssid_q;
    end

endmodule

// File: rtl/cfginv_seq_chk.sv
module cfginv_seq_chk #(
    parameter int SID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             inv_valid,
    input logic [1:0]       inv_op,
    input logic [SID_W-1:0] inv_sid,
    input logic             cmd_err,
    input logic             step_done
);

    AST_BUSY_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !cmd_ready); // R9

    AST_HOLD_UNTIL_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !step_done |=> inv_valid && $stable(inv_sid) && $stable(inv_op)); // R8

    AST_SID_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && step_done |=> !inv_valid || (inv_sid == SID_W'($past(inv_sid) + 1'b1))); // R4

    AST_DONE_FREES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && step_done |=> cmd_ready || inv_valid); // R9

    AST_ALL_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && (inv_op == 2'd2) && step_done |=> !inv_valid); // R3

    AST_SSID_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && (inv_op == 2'd1) && step_done |=> !inv_valid); // R6

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err); // R10

    AST_ERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !inv_valid); // R10

endmodule

bind cfginv_seq cfginv_seq_chk #(
    .SID_W (SID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .inv_valid (inv_valid),
    .inv_op    (inv_op),
    .inv_sid   (inv_sid),
    .cmd_err   (cmd_err),
    .step_done (all_acked)
);

// File: tb/sim_cfginv_seq.sv
module sim_cfginv_seq;

    localparam int SID_W  = 8;
    localparam int SSID_W = 6;
    localparam int NUM_IF = 3;
    localparam int NT     = 1 + 2 * NUM_IF;
    localparam int LOGN   = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [2:0]        cmd_kind = '0;
    logic [SID_W-1:0]  cmd_sid = '0;
    logic [SSID_W-1:0] cmd_ssid = '0;
    logic [4:0]        cmd_range = '0;
    logic              inv_valid;
    logic [1:0]        inv_op;
    logic [SID_W-1:0]  inv_sid;
    logic [SSID_W-1:0] inv_ssid;
    logic              cfg_ack;
    logic [NUM_IF-1:0] utlb_ack;
    logic [NUM_IF-1:0] mtlb_ack;
    logic              cmd_err;

    logic [NT-1:0]     ack_r = '0;
    int                hold_t = -1;
    int                checks = 0;
    int                failures = 0;
    bit                finished = 1'b0;

    logic [1:0]        log_op   [LOGN];
    logic [SID_W-1:0]  log_sid  [LOGN];
    logic [SSID_W-1:0] log_ssid [LOGN];
    int                log_n = 0;

    always #2 clk = ~clk;

    assign cfg_ack  = ack_r[0];
    assign utlb_ack = ack_r[NUM_IF:1];
    assign mtlb_ack = ack_r[2*NUM_IF:NUM_IF+1];

    cfginv_seq #(
        .SID_W  (SID_W),
        .SSID_W (SSID_W),
        .NUM_IF (NUM_IF)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_kind  (cmd_kind),
        .cmd_sid   (cmd_sid),
        .cmd_ssid  (cmd_ssid),
        .cmd_range (cmd_range),
        .inv_valid (inv_valid),
        .inv_op    (inv_op),
        .inv_sid   (inv_sid),
        .inv_ssid  (inv_ssid),
        .cfg_ack   (cfg_ack),
        .utlb_ack  (utlb_ack),
        .mtlb_ack  (mtlb_ack),
        .cmd_err   (cmd_err)
    );

    // Listener model and operation log, all on the falling edge
    logic             pv = 1'b0;
    logic [SID_W-1:0] psid = '0;
    bit   [NT-1:0]    pend = '0;
    int               cnt [NT];

    always @(negedge clk) begin
        if (!rst_n) begin
            pv    = 1'b0;
            pend  = '0;
            ack_r = '0;
        end else begin
            if (inv_valid && (!pv || inv_sid != psid)) begin
                if (log_n < LOGN) begin
                    log_op[log_n]   = inv_op;
                    log_sid[log_n]  = inv_sid;
                    log_ssid[log_n] = inv_ssid;
                end
                log_n = log_n + 1;
                for (int t = 0; t < NT; t++) begin
                    pend[t] = 1'b1;
                    cnt[t]  = (t * 3 + int'(inv_sid)) % 4;
                end
            end
            for (int t = 0; t < NT; t++) begin
                ack_r[t] = 1'b0;
                if (pend[t] && cnt[t] == 0 && hold_t != t) begin
                    ack_r[t] = 1'b1;
                    pend[t]  = 1'b0;
                end else if (pend[t] && cnt[t] > 0) begin
                    cnt[t] = cnt[t] - 1;
                end
            end
            pv   = inv_valid;
            psid = inv_sid;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Present a command on a falling edge where ready is high; return on the
    // falling edge after the accepting rising edge.
    task automatic send(input logic [2:0] k, input logic [SID_W-1:0] s,
                        input logic [SSID_W-1:0] ss, input logic [4:0] r);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        log_n     = 0;
        cmd_valid = 1'b1;
        cmd_kind  = k;
        cmd_sid   = s;
        cmd_ssid  = ss;
        cmd_range = r;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready(output int cycles);
        cycles = 0;
        while (!cmd_ready && cycles < 4000) begin
            @(negedge clk);
            cycles = cycles + 1;
        end
    endtask

    task automatic run_cmd(input logic [2:0] k, input logic [SID_W-1:0] s,
                           input logic [SSID_W-1:0] ss, input logic [4:0] r,
                           input string req);
        int n;
        int first;
        int eop;
        int w;
        int cyc;
        int bad_i;
        eop   = 0;
        first = int'(s);
        n     = 1;
        if (k == 3'd1) begin
            if (r == 5'd31) begin
                eop = 2;
            end else begin
                w = int'(r) + 1;
                if (w >= SID_W) begin
                    first = 0;
                    n     = 1 << SID_W;
                end else begin
                    first = int'(s) & ~((1 << w) - 1);
                    n     = 1 << w;
                end
            end
        end else if (k == 3'd2) begin
            eop = 1;
        end
        send(k, s, ss, r);
        chk(!cmd_ready && inv_valid, {req, " R9 busy after accept"},
            {cmd_ready, inv_valid}, 2'b01);
        wait_ready(cyc);
        chk(cmd_ready && !inv_valid, {req, " R9 ready after last ack"},
            {cmd_ready, inv_valid}, 2'b10);
        chk(log_n == n, {req, " op count"}, log_n, n);
        bad_i = -1;
        for (int i = 0; i < n && i < LOGN; i++) begin
            if (bad_i < 0) begin
                if (log_op[i] != 2'(eop)) bad_i = i;
                else if (eop != 2 && log_sid[i] != SID_W'(first + i)) bad_i = i;
                else if (eop == 1 && log_ssid[i] != ss) bad_i = i;
            end
        end
        if (bad_i >= 0) begin
            chk(1'b0, {req, " op content"},
                {log_op[bad_i], log_sid[bad_i]}, {2'(eop), SID_W'(first + bad_i)});
        end else begin
            chk(1'b1, req, 0, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin : stim
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_ready && !inv_valid && !cmd_err, "R1 during reset",
            {cmd_ready, inv_valid, cmd_err}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !inv_valid && !cmd_err, "R1 after reset",
            {cmd_ready, inv_valid, cmd_err}, 3'b100);

        // R2 single stream, R7 stream all substreams, R6 substream
        for (int s = 0; s < 256; s += 51) begin
            run_cmd(3'd0, SID_W'(s), 6'd0, 5'd0, "R2 stream");
            run_cmd(3'd3, SID_W'(s ^ 8'h5A), 6'd9, 5'd3, "R7 stream-all");
            run_cmd(3'd2, SID_W'(s + 7), SSID_W'(s >> 2), 5'd0, "R6 substream");
        end

        // R3 window everything
        run_cmd(3'd1, 8'hC3, 6'd0, 5'd31, "R3 everything");
        run_cmd(3'd1, 8'h00, 6'd0, 5'd31, "R3 everything zero sid");

        // R4 R5 sweep of every window size
        for (int r = 0; r < 31; r++) begin
            run_cmd(3'd1, SID_W'(8'hA5 ^ (r * 37)), 6'd0, 5'(r), "R4 R5 window");
            if (r < 6) begin
                run_cmd(3'd1, 8'hFF, 6'd0, 5'(r), "R5 window at top");
                run_cmd(3'd1, 8'h00, 6'd0, 5'(r), "R4 window at zero");
            end
        end

        // R10 unrecognised command kinds
        for (int k = 4; k < 8; k++) begin
            send(3'(k), 8'h11, 6'd1, 5'd2);
            chk(cmd_err && !inv_valid, "R10 err pulse", {cmd_err, inv_valid}, 2'b10);
            @(negedge clk);
            chk(!cmd_err && cmd_ready, "R10 err single cycle", {cmd_err, cmd_ready}, 2'b01);
            repeat (3) @(negedge clk);
            chk(log_n == 0 && !inv_valid, "R10 no operation", log_n, 0);
        end

        // R8 one listener withheld: the bus must hold its operation
        hold_t = NT - 1;
        send(3'd0, 8'h3C, 6'd0, 5'd0);
        repeat (15) @(negedge clk);
        chk(inv_valid && inv_sid == 8'h3C && !cmd_ready && log_n == 1,
            "R8 held by last main TLB", {inv_valid, inv_sid}, {1'b1, 8'h3C});
        hold_t = -1;
        wait_ready(cyc);
        chk(log_n == 1 && cmd_ready, "R8 completes after release", log_n, 1);

        hold_t = 0;
        send(3'd1, 8'h47, 6'd0, 5'd1);
        repeat (12) @(negedge clk);
        chk(inv_valid && inv_sid == 8'h44 && log_n == 1,
            "R8 window held by config cache", inv_sid, 8'h44);
        hold_t = -1;
        wait_ready(cyc);
        chk(log_n == 4 && log_sid[3] == 8'h47, "R8 window resumes", log_n, 4);

        report();
    end

endmodule